// File: doc/BRIEF.md
# Fractional and Integer Clock-Enable Generator

This block turns a fast reference clock into a stream of single-cycle enable pulses whose average rate is a programmable fraction of the clock rate. The first stage is a fractional rate stage. It is set by an increment value K and a pre-computed decrement value L−K, and it emits on average K ticks out of every L clocks. The second stage is an integer prescaler. It counts those ticks and fires once for every N+1 of them. The enable therefore arrives on average K/(L·(N+1)) times per clock.

A single 32-bit configuration word carries all three settings and is sampled on every clock. Downstream logic uses the enable to pace a bit-rate engine off the reference clock without a second clock domain. A zero decrement value bypasses the fractional stage, so every clock counts as a tick and only the integer prescaler divides the rate.

Top module: `frac_clk_enable`

## Requirements
- R1: Fields of `cfg_word`: decrement value in bits [26:16], increment value in bits [15:8], integer denominator N in bits [7:0]. Bits [31:27] have no effect on `en_out`.
- R2: While `rst` is sampled high at a rising edge, the accumulator and the integer counter are cleared and `en_out` is 0 after that edge.
- R3: With an all-zero configuration word, `en_out` is 1 after every rising edge that follows reset release.
- R4: Over C clocks from reset release with a constant legal setting (K < L), the number of enables equals floor(floor(C·K/L)/(N+1)).
- R5: A decrement value of zero (K = L, including K = L = 0) makes the fractional stage tick on every clock, so C clocks yield floor(C/(N+1)) enables and the stage never stalls.
- R6: With N held constant, two enables are never closer than N+1 clocks.
- R7: `en_out` rises only in the cycle after a fractional tick, and it is high for the one clock in which the integer counter wraps.
- R8: A new configuration word takes effect at the next rising edge without any reset of the counters.
- R9: The fractional accumulator never wraps, even at the largest field values (decrement 2047, increment 255), so the rate in R4 holds there too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Rate configuration: decrement, increment and denominator fields |
| en_out | output | 1 | Single-cycle enable pulse |

## Verification
The assertions check on every cycle that a zero decrement forces a fractional tick, that each enable follows a tick, that enables keep at least N+1 cycles apart while N is unchanged, and that reset clears both counters. Exact long-run pulse counts cannot be seen from any single cycle. Only the bench's scenarios show them: several K/L/N settings, the bypass and illegal-equal settings, the widest field values, reserved bits set, and a configuration change made mid-run without reset.

// File: rtl/fce_pkg.sv
package fce_pkg;
    localparam int CFG_W   = 32;
    localparam int DEC_W   = 11;
    localparam int INC_W   = 8;
    localparam int N_W     = 8;
    localparam int DEC_LSB = 16;
    localparam int INC_LSB = 8;
    localparam int N_LSB   = 0;
    localparam int RSV_LSB = DEC_LSB + DEC_W;
    // one spare bit above the wider of the two step fields keeps acc + inc in range
    localparam int ACC_W   = ((DEC_W > INC_W) ? DEC_W : INC_W) + 1;

    typedef struct packed {
        logic [DEC_W-1:0] dec;
        logic [INC_W-1:0] inc;
        logic [N_W-1:0]   n;
    } rate_cfg_t;
endpackage

// File: rtl/fce_cfg_split.sv
module fce_cfg_split
    import fce_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output rate_cfg_t        cfg
);
    logic unused_rsv;

    always_comb begin
        cfg.dec = cfg_word[DEC_LSB +: DEC_W];
        cfg.inc = cfg_word[INC_LSB +: INC_W];
        cfg.n   = cfg_word[N_LSB   +: N_W];
    end

    // reserved bits are deliberately dropped
    assign unused_rsv = ^cfg_word[CFG_W-1:RSV_LSB];
endmodule

// File: rtl/fce_frac_stage.sv
module fce_frac_stage #(
    parameter int DEC_W = fce_pkg::DEC_W,
    parameter int INC_W = fce_pkg::INC_W,
    parameter int ACC_W = fce_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEC_W-1:0] dec_i,
    input  logic [INC_W-1:0] inc_i,
    output logic             tick_o,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } frac_state_t;

    frac_state_t st_d, st_q;
    logic [ACC_W-1:0] dec_ext, inc_ext;
    logic             tick_d;

    always_comb begin
        dec_ext = {{(ACC_W-DEC_W){1'b0}}, dec_i};
        inc_ext = {{(ACC_W-INC_W){1'b0}}, inc_i};
        st_d    = st_q;
        tick_d  = (st_q.acc >= dec_ext);
        if (tick_d) begin
            st_d.acc = st_q.acc - dec_ext;
        end else begin
            st_d.acc = st_q.acc + inc_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick_d;
    assign acc_o  = st_q.acc;
endmodule

// File: rtl/fce_int_stage.sv
module fce_int_stage #(
    parameter int N_W = fce_pkg::N_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic [N_W-1:0] n_i,
    output logic           en_o,
    output logic [N_W-1:0] cnt_o
);
    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic           en;
    } int_state_t;

    int_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        // ">=" lets a lowered N wrap at once instead of running to the top
        wrap    = tick_i && (st_q.cnt >= n_i);
        st_d.en = wrap;
        if (wrap) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/frac_clk_enable.sv
module frac_clk_enable
    import fce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             en_out
);
    rate_cfg_t        cfg_s;
    logic [DEC_W-1:0] dec_w;
    logic [INC_W-1:0] inc_w;
    logic [N_W-1:0]   n_w;
    logic             frac_tick;
    logic [ACC_W-1:0] acc_w;
    logic [N_W-1:0]   cnt_w;

    fce_cfg_split u_split (
        .cfg_word (cfg_word),
        .cfg      (cfg_s)
    );

    assign dec_w = cfg_s.dec;
    assign inc_w = cfg_s.inc;
    assign n_w   = cfg_s.n;

    fce_frac_stage #(
        .DEC_W (DEC_W),
        .INC_W (INC_W),
        .ACC_W (ACC_W)
    ) u_frac (
        .clk    (clk),
        .rst    (rst),
        .dec_i  (dec_w),
        .inc_i  (inc_w),
        .tick_o (frac_tick),
        .acc_o  (acc_w)
    );

    fce_int_stage #(
        .N_W (N_W)
    ) u_int (
        .clk    (clk),
        .rst    (rst),
        .tick_i (frac_tick),
        .n_i    (n_w),
        .en_o   (en_out),
        .cnt_o  (cnt_w)
    );
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
    parameter int DEC_W = fce_pkg::DEC_W,
    parameter int N_W   = fce_pkg::N_W,
    parameter int ACC_W = fce_pkg::ACC_W
) (
    input logic             clk,
    input logic             rst,
    input logic [DEC_W-1:0] dec,
    input logic [N_W-1:0]   n,
    input logic             tick,
    input logic [ACC_W-1:0] acc,
    input logic [N_W-1:0]   cnt,
    input logic             en
);
    localparam int DIST_W = N_W + 2;
    localparam logic [DIST_W-1:0] DIST_MAX = '1;

    logic [DIST_W-1:0] dist_q;
    logic              have_prev_q;
    logic              n_kept_q;
    logic [N_W-1:0]    n_prev_q;
    logic              rst_d_q;

    always_ff @(posedge clk) begin
        n_prev_q <= n;
        rst_d_q  <= rst;
        if (rst) begin
            dist_q      <= '0;
            have_prev_q <= 1'b0;
            n_kept_q    <= 1'b0;
        end else if (en) begin
            dist_q      <= {{(DIST_W-1){1'b0}}, 1'b1};
            have_prev_q <= 1'b1;
            n_kept_q    <= 1'b1;
        end else begin
            if (dist_q != DIST_MAX) dist_q <= dist_q + 1'b1;
            if (n != n_prev_q) n_kept_q <= 1'b0;
        end
    end

    // counters read zero at the edge after a sampled reset
    always_ff @(posedge clk) begin
        if (rst_d_q === 1'b1) begin
            AST_RESET_CLEAR: assert (acc == '0 && cnt == '0 && !en); // R2
        end
    end

    AST_ZERO_DEC_TICKS: assert property (@(posedge clk) disable iff (rst)
        (dec == '0) |-> tick); // R5

    AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        en |-> $past(tick)); // R7

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
        (en && have_prev_q && n_kept_q && (n == n_prev_q))
            |-> (dist_q >= ({{(DIST_W-N_W){1'b0}}, n} + 1'b1))); // R6
endmodule

bind frac_clk_enable fce_checker #(
    .DEC_W (fce_pkg::DEC_W),
    .N_W   (fce_pkg::N_W),
    .ACC_W (fce_pkg::ACC_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .dec  (dec_w),
    .n    (n_w),
    .tick (frac_tick),
    .acc  (acc_w),
    .cnt  (cnt_w),
    .en   (en_out)
);

// File: tb/tb_frac_clk_enable.sv
module tb_frac_clk_enable;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        en_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    bit mon_busy = 0;

    typedef struct {
        int unsigned cycles;
        int unsigned exp_cnt;
        int unsigned n;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    frac_clk_enable dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .en_out   (en_out)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] mk_word(int unsigned k, int unsigned l,
                                            int unsigned n, int unsigned rsv);
        logic [31:0] w;
        w        = '0;
        w[31:27] = 5'(rsv);
        w[26:16] = 11'(l - k);
        w[15:8]  = 8'(k);
        w[7:0]   = 8'(n);
        return w;
    endfunction

    function automatic int unsigned exp_count(int unsigned c, int unsigned k,
                                              int unsigned l, int unsigned n);
        longint unsigned ticks;
        ticks = (l == 0) ? c : (longint'(c) * k) / l;
        return int'(ticks / (n + 1));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: programs a case and pushes its expectation
    task automatic run_case(int unsigned k, int unsigned l, int unsigned n,
                            int unsigned rsv, int unsigned c, bit do_reset,
                            string tag);
        exp_item_t it;
        if (do_reset) begin
            rst      = 1'b1;
            cfg_word = mk_word(k, l, n, rsv);
            @(negedge clk);
            check(en_out == 1'b0, "R2", {tag, " en during reset"}, int'(en_out), 0);
            @(negedge clk);
            rst = 1'b0;
        end else begin
            cfg_word = mk_word(k, l, n, rsv);
        end
        it.cycles  = c;
        it.exp_cnt = exp_count(c, k, l, n);
        it.n       = n;
        it.tag     = tag;
        exp_q.push_back(it);
        repeat (c + 1) @(negedge clk);
    endtask

    // monitor: counts pulses over the window and compares
    initial begin
        forever begin
            exp_item_t it;
            int unsigned cnt;
            int unsigned min_gap;
            int          last_idx;
            wait (exp_q.size() > 0);
            it       = exp_q.pop_front();
            mon_busy = 1;
            cnt      = 0;
            min_gap  = 32'hFFFF_FFFF;
            last_idx = -1;
            for (int i = 0; i < int'(it.cycles); i++) begin
                @(negedge clk);
                if (en_out) begin
                    cnt++;
                    if (last_idx >= 0 && int'(min_gap) > (i - last_idx))
                        min_gap = i - last_idx;
                    last_idx = i;
                end
            end
            check(cnt == it.exp_cnt, it.tag, "enable count",
                  int'(cnt), int'(it.exp_cnt));
            if (min_gap != 32'hFFFF_FFFF)
                check(min_gap >= it.n + 1, "R6", {it.tag, " min gap"},
                      int'(min_gap), int'(it.n + 1));
            else
                check(1'b1, "R6", {it.tag, " min gap"}, 0, 0);
            mon_busy = 0;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(en_out == 1'b0, "R2", "en held low in reset", int'(en_out), 0);
        run_case(0, 0, 0, 0, 50, 1, "R3 zero word");
        run_case(3, 8, 0, 0, 400, 1, "R4 k3 l8 n0");
        run_case(3, 8, 2, 0, 600, 1, "R4 k3 l8 n2");
        run_case(1, 3, 4, 0, 3000, 1, "R4 k1 l3 n4");
        run_case(255, 2302, 0, 0, 5000, 1, "R9 widest fields");
        run_case(200, 2247, 3, 0, 4000, 1, "R9 wide fields n3");
        run_case(0, 0, 6, 0, 700, 1, "R5 bypass n6");
        run_case(5, 5, 1, 0, 300, 1, "R5 k equals l");
        run_case(3, 8, 0, 31, 400, 1, "R1 reserved bits set");
        run_case(7, 19, 2, 0, 500, 1, "R7 k7 l19 n2");
        run_case(0, 0, 0, 0, 64, 0, "R8 live change to zero");
        run_case(0, 0, 255, 0, 1024, 1, "R6 n255");
        // R2: reset mid-stream silences the output at the next edge
        rst = 1'b1;
        @(negedge clk);
        check(en_out == 1'b0, "R2", "en after mid-run reset", int'(en_out), 0);
        rst = 1'b0;
        wait (exp_q.size() == 0 && mon_busy == 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule